// File: doc/BRIEF.md
# Windowed Slave-to-PCI Express Address Translator

This block maps an address arriving on a 32-bit memory-mapped slave window onto a wider PCI Express address. The slave window is split into Q equal pages. The page number, taken from the slave address just above the pass-through field, selects one entry of a small table. That entry supplies every PCI Express address bit above the pass-through field, together with a 2-bit space code that downstream request-forming logic uses to choose the kind of transaction. The pass-through bits are copied unchanged.

Software fills the table through a word-wide register write port. Each entry takes two register slots. The write port is independent of the translation path, so entries can be changed while traffic flows. Each translation is registered and appears one clock after its request.

Top module: `pcie_window_xlat`

## Requirements
- R1: Bits [PASS_W-1:0] of `xl_addr` equal bits [PASS_W-1:0] of the `req_addr` accepted one clock earlier.
- R2: Bits [PCI_W-1:PASS_W] of `xl_addr` are the address field of the entry whose number is `req_addr[SLV_W-1:PASS_W]`.
- R3: `xl_space` equals the 2-bit space code held by that same entry.
- R4: Bits [31:SLV_W] of `req_addr` have no effect on `xl_addr` or `xl_space`.
- R5: `xl_valid` is high exactly in the cycle after a cycle in which `req_valid` was high at the clock edge, so latency is one clock.
- R6: If an entry is written in the same cycle that a request selects it, that request gets the entry's old contents, and the next request gets the new contents.
- R7: After reset, `xl_valid` is low, `xl_addr` and `xl_space` are zero, and every entry holds a zero address and space code 0.
- R8: Entry e uses register slot 2e and slot 2e+1. In slot 2e, bits [1:0] are the space code and bits [31:PASS_W] become PCI Express address bits [31:PASS_W]; bits [PASS_W-1:2] are ignored. Slot 2e+1 bits [PCI_W-33:0] become PCI Express address bits [PCI_W-1:32].
- R9: While `req_valid` is low, `xl_addr` and `xl_space` keep their previous values.
- R10: A write to the register slots of one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A slave address is presented this cycle |
| req_addr | input | 32 | Slave address to translate |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | log2(2Q) | Register slot being written (2e = low word, 2e+1 = high word) |
| cfg_wr_data | input | 32 | Register write data |
| xl_valid | output | 1 | Translated result is valid |
| xl_addr | output | PCI_W | Translated PCI Express address |
| xl_space | output | 2 | Space code of the selected entry |

## Verification
A corrupted table entry shows at the ports on the first request that selects its page, one clock after that request, as wrong high address bits or a wrong space code. Other pages still translate correctly. A wrong page decode shows as another entry's contents and is caught by giving every entry distinct values. A fault in the write steering or in the same-cycle ordering shows up as an unchanged, stale or too-early value in the very next translation.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   localparam int unsigned XLT_REG_W   = 32;
   localparam int unsigned XLT_SPACE_W = 2;

   typedef logic [XLT_SPACE_W-1:0] xlt_space_t;

   localparam xlt_space_t XLT_SPACE_RST = '0;

   // Register slot of the low word of entry e.
   function automatic int unsigned xlt_lo_slot(input int unsigned e);
      return 2 * e;
   endfunction

   // Register slot of the high word of entry e.
   function automatic int unsigned xlt_hi_slot(input int unsigned e);
      return 2 * e + 1;
   endfunction

endpackage

// File: rtl/xlt_table.sv
module xlt_table
   import xlt_pkg::*;
#(
   parameter  int unsigned PASS_W  = 20,
   parameter  int unsigned SLV_W   = 22,
   parameter  int unsigned PCI_W   = 64,
   localparam int unsigned IDX_W   = SLV_W - PASS_W,
   localparam int unsigned NUM_ENT = 1 << IDX_W,
   localparam int unsigned RIDX_W  = IDX_W + 1,
   localparam int unsigned HI_W    = PCI_W - PASS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [RIDX_W-1:0]    wr_idx,
   input  logic [XLT_REG_W-1:0] wr_data,
   output logic [HI_W-1:0]      ent_addr  [NUM_ENT],
   output xlt_space_t           ent_space [NUM_ENT]
);

   // Top bit of the low word that carries address bits.
   localparam int unsigned LO_TOP = (PCI_W > XLT_REG_W) ? XLT_REG_W - 1 : PCI_W - 1;
   localparam int unsigned LO_FW  = LO_TOP - PASS_W + 1;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic             lo_hit;
      logic [LO_FW-1:0] lo_q;
      xlt_space_t       sp_q;

      assign lo_hit = wr_en && (wr_idx == RIDX_W'(xlt_lo_slot(e)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            sp_q <= XLT_SPACE_RST;
         end else if (lo_hit) begin
            lo_q <= wr_data[LO_TOP:PASS_W];
            sp_q <= wr_data[XLT_SPACE_W-1:0];
         end
      end

      assign ent_space[e] = sp_q;

      if (PCI_W > XLT_REG_W) begin : g_wide
         localparam int unsigned UP_W = PCI_W - XLT_REG_W;
         logic            hi_hit;
         logic [UP_W-1:0] up_q;

         assign hi_hit = wr_en && (wr_idx == RIDX_W'(xlt_hi_slot(e)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q <= '0;
            end else if (hi_hit) begin
               up_q <= wr_data[UP_W-1:0];
            end
         end

         assign ent_addr[e] = {up_q, lo_q};
      end else begin : g_narrow
         assign ent_addr[e] = lo_q;
      end

      AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_idx[RIDX_W-1:1] == IDX_W'(e))) |=>
            ($stable(ent_addr[e]) && $stable(ent_space[e])))
         else $error("entry changed without a write to its slots"); // R10

      AST_SPACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_idx == RIDX_W'(xlt_lo_slot(e)))) |=>
            (ent_space[e] == $past(wr_data[XLT_SPACE_W-1:0])))
         else $error("space code not taken from low word"); // R8
   end

endmodule

// File: rtl/xlt_lookup.sv
module xlt_lookup
   import xlt_pkg::*;
#(
   parameter  int unsigned PASS_W  = 20,
   parameter  int unsigned SLV_W   = 22,
   parameter  int unsigned PCI_W   = 64,
   localparam int unsigned IDX_W   = SLV_W - PASS_W,
   localparam int unsigned NUM_ENT = 1 << IDX_W,
   localparam int unsigned HI_W    = PCI_W - PASS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [XLT_REG_W-1:0] req_addr,
   input  logic [HI_W-1:0]      ent_addr  [NUM_ENT],
   input  xlt_space_t           ent_space [NUM_ENT],
   output logic                 xl_valid,
   output logic [PCI_W-1:0]     xl_addr,
   output xlt_space_t           xl_space
);

   logic [IDX_W-1:0] page;
   logic             unused_req_bits;

   assign page            = req_addr[SLV_W-1:PASS_W];
   assign unused_req_bits = ^req_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_valid <= 1'b0;
         xl_addr  <= '0;
         xl_space <= XLT_SPACE_RST;
      end else begin
         xl_valid <= req_valid;
         if (req_valid) begin
            xl_addr  <= {ent_addr[page], req_addr[PASS_W-1:0]};
            xl_space <= ent_space[page];
         end
      end
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> xl_valid)
      else $error("valid not returned after one clock"); // R5

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !xl_valid)
      else $error("valid without a request"); // R5

   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (xl_addr[PASS_W-1:0] == $past(req_addr[PASS_W-1:0])))
      else $error("pass-through bits altered"); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(xl_addr) && $stable(xl_space)))
      else $error("result changed while idle"); // R9

endmodule

// File: rtl/pcie_window_xlat.sv
module pcie_window_xlat
   import xlt_pkg::*;
#(
   parameter  int unsigned PASS_W = 20,
   parameter  int unsigned SLV_W  = 22,
   parameter  int unsigned PCI_W  = 64,
   localparam int unsigned RIDX_W = SLV_W - PASS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   input  logic              cfg_wr_en,
   input  logic [RIDX_W-1:0] cfg_wr_idx,
   input  logic [31:0]       cfg_wr_data,
   output logic              xl_valid,
   output logic [PCI_W-1:0]  xl_addr,
   output logic [1:0]        xl_space
);

   localparam int unsigned IDX_W   = SLV_W - PASS_W;
   localparam int unsigned NUM_ENT = 1 << IDX_W;
   localparam int unsigned HI_W    = PCI_W - PASS_W;

   initial begin
      assert (PASS_W >= XLT_SPACE_W)
         else $error("pass-through field must cover the space code bits");
      assert (SLV_W > PASS_W && SLV_W <= XLT_REG_W)
         else $error("page field must lie inside the slave address");
      assert (IDX_W <= 8)
         else $error("table depth too large");
      assert (PCI_W > PASS_W && PCI_W <= 2 * XLT_REG_W)
         else $error("PCI address width out of range");
   end

   logic [HI_W-1:0] ent_addr  [NUM_ENT];
   xlt_space_t      ent_space [NUM_ENT];
   xlt_space_t      space_q;

   xlt_table #(
      .PASS_W (PASS_W),
      .SLV_W  (SLV_W),
      .PCI_W  (PCI_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_idx    (cfg_wr_idx),
      .wr_data   (cfg_wr_data),
      .ent_addr  (ent_addr),
      .ent_space (ent_space)
   );

   xlt_lookup #(
      .PASS_W (PASS_W),
      .SLV_W  (SLV_W),
      .PCI_W  (PCI_W)
   ) u_lookup (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .ent_addr  (ent_addr),
      .ent_space (ent_space),
      .xl_valid  (xl_valid),
      .xl_addr   (xl_addr),
      .xl_space  (space_q)
   );

   assign xl_space = space_q;

endmodule

// File: tb/tb_pcie_window_xlat.sv
`timescale 1ns/1ps
module tb_pcie_window_xlat;

   localparam int PASS_W = 20;
   localparam int SLV_W  = 22;
   localparam int PCI_W  = 64;
   localparam int HI_W   = PCI_W - PASS_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [31:0]       req_addr = '0;
   logic              cfg_wr_en = 1'b0;
   logic [2:0]        cfg_wr_idx = '0;
   logic [31:0]       cfg_wr_data = '0;
   logic              xl_valid;
   logic [PCI_W-1:0]  xl_addr;
   logic [1:0]        xl_space;

   int n_chk  = 0;
   int n_fail = 0;

   logic [HI_W-1:0] mdl_hi [4];
   logic [1:0]      mdl_sp [4];

   always #2.5 clk = ~clk;

   pcie_window_xlat #(.PASS_W(PASS_W), .SLV_W(SLV_W), .PCI_W(PCI_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
      .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_space(xl_space)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_lo(input int e, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_idx = 3'(2 * e); cfg_wr_data = d;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
      mdl_hi[e][11:0] = d[31:20];
      mdl_sp[e] = d[1:0];
   endtask

   task automatic wr_hi(input int e, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_idx = 3'(2 * e + 1); cfg_wr_data = d;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
      mdl_hi[e][43:12] = d;
   endtask

   task automatic trans(input logic [31:0] a, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk({tag, " R5 valid"}, 64'(xl_valid), 64'd1);
      chk({tag, " R1/R2 addr"}, xl_addr, {mdl_hi[a[21:20]], a[19:0]});
      chk({tag, " R3 space"}, 64'(xl_space), 64'(mdl_sp[a[21:20]]));
   endtask

   task automatic t_reset;
      chk("R7 valid after reset", 64'(xl_valid), 64'd0);
      chk("R7 addr after reset", xl_addr, 64'd0);
      chk("R7 space after reset", 64'(xl_space), 64'd0);
      for (int e = 0; e < 4; e++) trans(32'(e << 20) | 32'h000A_5C3, "R7 cleared entry");
   endtask

   task automatic t_program;
      // Junk in low-word bits [19:2] must be ignored (R8).
      wr_lo(0, 32'hABC0_0001); wr_hi(0, 32'h1234_5678);
      wr_lo(1, 32'h0017_FFFE); wr_hi(1, 32'hFFFF_0000);
      wr_lo(2, 32'h5550_0003); wr_hi(2, 32'h0000_0001);
      wr_lo(3, 32'hFFF2_4680); wr_hi(3, 32'hDEAD_BEEF);
      trans(32'h0001_2345, "R8 entry0");
      trans(32'h001F_FFFF, "R8 entry1");
      trans(32'h0020_0000, "R8 entry2");
      trans(32'h003A_BCDE, "R8 entry3");
      chk("R8 exact entry3", xl_addr, 64'hDEAD_BEEF_FFFA_BCDE);
   endtask

   task automatic t_upper_ignored;
      trans(32'hFFC5_4321, "R4 upper bits set");
      trans(32'h8021_0F0F, "R4 upper bits mixed");
   endtask

   task automatic t_latency_hold;
      logic [63:0] held;
      logic [1:0]  held_sp;
      trans(32'h0030_0042, "R5 single");
      held = xl_addr; held_sp = xl_space;
      @(negedge clk); req_addr = 32'h0010_7777;
      @(posedge clk); #1;
      chk("R5 valid drops", 64'(xl_valid), 64'd0);
      chk("R9 addr held", xl_addr, held);
      chk("R9 space held", 64'(xl_space), 64'(held_sp));
   endtask

   task automatic t_collision;
      logic [63:0] old_a;
      logic [1:0]  old_sp;
      old_a  = {mdl_hi[1], 20'h0_0ABC};
      old_sp = mdl_sp[1];
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0010_0ABC;
      cfg_wr_en = 1'b1; cfg_wr_idx = 3'd2; cfg_wr_data = 32'h9990_0002;
      @(posedge clk); #1;
      req_valid = 1'b0; cfg_wr_en = 1'b0;
      chk("R6 same-cycle old addr", xl_addr, old_a);
      chk("R6 same-cycle old space", 64'(xl_space), 64'(old_sp));
      mdl_hi[1][11:0] = 12'h999;
      mdl_sp[1] = 2'd2;
      trans(32'h0010_0ABC, "R6 next sees new");
   endtask

   task automatic t_isolation;
      wr_hi(2, 32'h0BAD_F00D);
      wr_lo(2, 32'h0010_0000);
      trans(32'h0000_1111, "R10 entry0 untouched");
      trans(32'h0010_2222, "R10 entry1 untouched");
      trans(32'h0020_3333, "R10 entry2 rewritten");
      trans(32'h0030_4444, "R10 entry3 untouched");
   endtask

   initial begin
      for (int e = 0; e < 4; e++) begin mdl_hi[e] = '0; mdl_sp[e] = '0; end
      repeat (3) @(posedge clk);
      #1;
      t_reset_pre: chk("R7 valid in reset", 64'(xl_valid), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset;
      t_program;
      t_upper_ignored;
      t_latency_hold;
      t_collision;
      t_isolation;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule